// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a tiny 8-bit processor built around a single accumulator, a carry flag and a program counter. Its whole instruction set is four operations: a bitwise NOR of the accumulator with a memory word, an add of a memory word into the accumulator, a store of the accumulator, and a branch that is taken only while carry is clear. Code and data share one small memory that sits outside the block behind a synchronous port. Read data returns one clock after the address is presented.

Richer operations are built as short sequences of the four. NOR with an all-ones word clears the accumulator. NOR with zero followed by an add of one negates it, so a − b is formed as a + (−b), and carry then tells whether the result is non-negative. A branch that falls through clears carry, so a second branch placed right after it always jumps. A taken branch whose target is its own address is treated as the end of the program: the core stops and raises a halt output.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the accumulator, carry and program counter are zero. The core presents address 0, keeps the write enable low and keeps halt low.
- R2: An instruction word carries its opcode in bits [7:6] and a direct word address in bits [5:0], giving a 64-word space. The opcode values are 00 NOR, 01 ADD, 10 STA and 11 JCC.
- R3: NOR and ADD take three cycles: fetch at the program counter, decode with the operand address on the port, and execute with the operand on read data. STA and JCC take two cycles: fetch, then decode. The address of the current instruction's operand or target stays on the port during execute.
- R4: NOR loads the accumulator with the complement of (accumulator OR operand). An all-ones operand therefore yields zero. Carry is not changed.
- R5: ADD loads the accumulator with the low 8 bits of accumulator plus operand and sets carry to the carry-out of that sum.
- R6: STA drives the accumulator onto write data with write enable high for exactly the decode cycle, at the instruction's address. Accumulator and carry are unchanged.
- R7: JCC with carry clear loads the program counter with its target and leaves carry clear.
- R8: JCC with carry set does not branch. It clears carry and advances the program counter by one, so a second JCC right after it always branches.
- R9: A taken JCC whose target equals its own address raises halt. Halt then stays high with no further writes, and the address port holds that instruction's address until reset.
- R10: A program that finds the greatest common divisor by repeated subtraction, built only from these four operations, halts with the divisor in the word that held b. Starting from a=10 and b=30, that word ends at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with the clock |
| mem_addr | output | 6 | Word address to the shared memory |
| mem_wdata | output | 8 | Data to store, valid while mem_we is high |
| mem_we | output | 1 | Write strobe for the addressed word |
| mem_rdata | input | 8 | Word read at the address of the previous cycle |
| halted | output | 1 | High once the core has stopped on a self-branch |

## Verification
The assertions assume that the memory behaves as a one-cycle synchronous RAM. Read data in any cycle must be the word stored at the previous cycle's address, as it was before that cycle's write, and the carry and branch checks rely on this. They also assume that reset is released away from the rising edge. The bench models its memory exactly that way and changes reset only on falling edges. It runs self-contained programs that never rely on undefined words, and each program ends in a self-branch so that the run always finishes in halt.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_NOR = 2'b00,
    OP_ADD = 2'b01,
    OP_STA = 2'b10,
    OP_JCC = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'b00,
    ST_DECODE = 2'b01,
    ST_EXEC   = 2'b10,
    ST_HALT   = 2'b11
  } state_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);

  logic [DATA_W:0] sum;

  assign sum = {1'b0, acc_in} + {1'b0, opnd};

  always_comb begin
    result    = acc_in;
    carry_out = carry_in;
    case (op)
      OP_NOR: begin
        result    = ~(acc_in | opnd);
        carry_out = carry_in;
      end
      OP_ADD: begin
        result    = sum[DATA_W-1:0];
        carry_out = sum[DATA_W];
      end
      default: begin
        result    = acc_in;
        carry_out = carry_in;
      end
    endcase
  end

endmodule

// File: rtl/acc_branch.sv
module acc_branch #(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic              carry,
  output logic              take,
  output logic              self_loop,
  output logic [ADDR_W-1:0] pc_inc,
  output logic [ADDR_W-1:0] pc_jcc
);

  assign pc_inc    = pc + 1'b1;
  assign take      = ~carry;
  assign self_loop = take && (target == pc);
  assign pc_jcc    = take ? target : pc_inc;

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    dec_op,
  input  logic   halt_req,
  output state_e state
);

  state_e state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_FETCH:  state_nxt = ST_DECODE;
      ST_DECODE: begin
        case (dec_op)
          OP_NOR, OP_ADD: state_nxt = ST_EXEC;
          OP_STA:         state_nxt = ST_FETCH;
          default:        state_nxt = halt_req ? ST_HALT : ST_FETCH;
        endcase
      end
      ST_EXEC:   state_nxt = ST_FETCH;
      default:   state_nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_nxt;
  end

  // R9: once stopped, the sequencer never leaves the halt state
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT);

  // R3: execute only ever follows a decode
  p_exec_after_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_EXEC |-> $past(state) == ST_DECODE);

  // R3: a fetch is always followed by a decode
  p_fetch_then_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> state == ST_DECODE);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [DATA_W-OPC_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic                       mem_we,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       halted
);

  localparam int ADDR_W = DATA_W - OPC_W;

  state_e            state;
  op_e               dec_op;
  logic [ADDR_W-1:0] dec_addr;

  logic [DATA_W-1:0] acc_q, acc_nxt;
  logic              carry_q, carry_nxt;
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic [ADDR_W-1:0] ir_addr_q;
  op_e               ir_op_q;

  logic acc_en, carry_en, pc_en, ir_en;

  logic [DATA_W-1:0] alu_res;
  logic              alu_carry;
  logic              br_take, br_self;
  logic [ADDR_W-1:0] pc_inc, pc_jcc;

  logic in_decode, in_exec;

  assign dec_op   = op_e'(mem_rdata[DATA_W-1 -: OPC_W]);
  assign dec_addr = mem_rdata[ADDR_W-1:0];

  assign in_decode = (state == ST_DECODE);
  assign in_exec   = (state == ST_EXEC);

  acc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_op   (dec_op),
    .halt_req (br_self),
    .state    (state)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (ir_op_q),
    .acc_in    (acc_q),
    .opnd      (mem_rdata),
    .carry_in  (carry_q),
    .result    (alu_res),
    .carry_out (alu_carry)
  );

  acc_branch #(.ADDR_W(ADDR_W)) u_branch (
    .pc        (pc_q),
    .target    (dec_addr),
    .carry     (carry_q),
    .take      (br_take),
    .self_loop (br_self),
    .pc_inc    (pc_inc),
    .pc_jcc    (pc_jcc)
  );

  // Memory port
  always_comb begin
    case (state)
      ST_DECODE: mem_addr = dec_addr;
      ST_EXEC:   mem_addr = ir_addr_q;
      default:   mem_addr = pc_q;
    endcase
  end

  assign mem_we    = in_decode && (dec_op == OP_STA);
  assign mem_wdata = acc_q;
  assign halted    = (state == ST_HALT);

  // Next-state logic for the architectural registers
  always_comb begin
    ir_en     = in_decode;

    acc_en    = in_exec;
    acc_nxt   = alu_res;

    carry_en  = in_exec || (in_decode && (dec_op == OP_JCC) && !br_take);
    carry_nxt = in_exec ? alu_carry : 1'b0;

    pc_en     = in_exec || (in_decode && ((dec_op == OP_STA) || (dec_op == OP_JCC)));
    pc_nxt    = (in_decode && (dec_op == OP_JCC)) ? pc_jcc : pc_inc;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= 1'b0;
    else if (carry_en) carry_q <= carry_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_addr_q <= '0;
      ir_op_q   <= OP_NOR;
    end else if (ir_en) begin
      ir_addr_q <= dec_addr;
      ir_op_q   <= dec_op;
    end
  end

  // R4: an all-ones operand clears the accumulator
  p_nor_allones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && ir_op_q == OP_NOR && mem_rdata == '1) |=> acc_q == '0);

  // R4: NOR leaves the flag alone
  p_nor_keeps_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && ir_op_q == OP_NOR) |=> $stable(carry_q));

  // R5: the flag and accumulator together hold the full sum
  p_add_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && ir_op_q == OP_ADD) |=>
      {carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(mem_rdata)}));

  // R6: a store strobes for one cycle and touches no register
  p_sta_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && $stable(acc_q) && $stable(carry_q));

  // R7: taken branch lands on its target, carry stays clear
  p_jcc_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decode && dec_op == OP_JCC && !carry_q) |=>
      !carry_q && pc_q == $past(mem_rdata[ADDR_W-1:0]));

  // R8: fall-through clears carry and steps the counter
  p_jcc_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decode && dec_op == OP_JCC && carry_q) |=>
      !carry_q && pc_q == $past(pc_q) + 1'b1);

  // R9: no writes and a frozen address once halted
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we && $stable(mem_addr));

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 64;
  localparam int RUN_LIMIT  = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic [7:0] mem_rdata;
  logic       halted;

  logic [7:0] mem [0:MEM_N-1];

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core u_acc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // One-cycle synchronous RAM, read before write
  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2: opcode in [7:6], address in [5:0]
  function automatic logic [7:0] enc(input int op, input int addr);
    return 8'(((op & 3) << 6) | (addr & 63));
  endfunction

  localparam int NOR = 0, ADD = 1, STA = 2, JCC = 3;

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
  endtask

  // Greatest common divisor by repeated subtraction (R10)
  task automatic load_gcd(input int a, input int b);
    clear_mem();
    mem[0]  = enc(NOR, 16);  // acc = 0
    mem[1]  = enc(NOR, 15);  // acc = ~b
    mem[2]  = enc(ADD, 18);  // acc = -b
    mem[3]  = enc(ADD, 14);  // acc = a - b
    mem[4]  = enc(JCC, 9);   // a < b
    mem[5]  = enc(STA, 14);  // a = a - b
    mem[6]  = enc(ADD, 16);  // carry clear iff a == 0
    mem[7]  = enc(JCC, 13);
    mem[8]  = enc(JCC, 0);   // always taken after fall-through
    mem[9]  = enc(NOR, 17);
    mem[10] = enc(ADD, 18);  // acc = b - a
    mem[11] = enc(STA, 15);
    mem[12] = enc(JCC, 0);
    mem[13] = enc(JCC, 13);  // halt
    mem[14] = 8'(a);
    mem[15] = 8'(b);
    mem[16] = 8'hFF;
    mem[17] = 8'h00;
    mem[18] = 8'h01;
  endtask

  // Flag-rule program
  task automatic load_flags();
    clear_mem();
    mem[0]  = enc(NOR, 40);
    mem[1]  = enc(ADD, 40);
    mem[2]  = enc(ADD, 41);
    mem[3]  = enc(STA, 43);
    mem[4]  = enc(NOR, 42);
    mem[5]  = enc(JCC, 9);
    mem[6]  = enc(STA, 44);
    mem[7]  = enc(JCC, 10);
    mem[8]  = enc(STA, 45);
    mem[9]  = enc(STA, 45);
    mem[10] = enc(JCC, 12);
    mem[11] = enc(STA, 45);
    mem[12] = enc(ADD, 41);
    mem[13] = enc(STA, 46);
    mem[14] = enc(JCC, 16);
    mem[15] = enc(JCC, 15);
    mem[40] = 8'hFF;
    mem[41] = 8'h01;
    mem[42] = 8'h00;
    mem[43] = 8'hAA;
    mem[44] = 8'h00;
    mem[45] = 8'h5A;
    mem[46] = 8'h33;
  endtask

  // Reset, then run a behavioural model alongside the core until halt
  task automatic run_prog(input string name, output int halt_pc);
    logic [7:0] m_mem [0:MEM_N-1];
    int   m_phase, m_pc, m_acc, m_c, m_ir, m_op, m_rd;
    int   ea, ewe, ewd, eh, post, cyc, opd, s;
    int   op, tgt;
    bit   ok_cycle;

    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(mem_we == 1'b0, "R1 we in reset", int'(mem_we), 0);
      check(halted == 1'b0, "R1 halt in reset", int'(halted), 0);
      check(mem_addr == 6'd0, "R1 addr in reset", int'(mem_addr), 0);
    end
    for (int i = 0; i < MEM_N; i++) m_mem[i] = mem[i];
    m_phase = 0; m_pc = 0; m_acc = 0; m_c = 0; m_ir = 0; m_op = 0; m_rd = 0;
    post = 0; cyc = 0; halt_pc = -1;
    @(negedge clk);
    rst_n = 1'b1;

    while (cyc < RUN_LIMIT && post < 4) begin
      #1;
      ewe = 0; ewd = 0; eh = 0;
      case (m_phase)
        0: ea = m_pc;
        1: begin
          ea = m_rd & 63;
          if (((m_rd >> 6) & 3) == STA) begin ewe = 1; ewd = m_acc; end
        end
        2: ea = m_ir;
        default: begin ea = m_pc; eh = 1; end
      endcase

      ok_cycle = (mem_addr == 6'(ea)) && (mem_we == ewe[0]) &&
                 (halted == eh[0]) && (!ewe[0] || mem_wdata == 8'(ewd));
      check(mem_addr == 6'(ea), {"R3 addr ", name}, int'(mem_addr), ea);
      check(mem_we == ewe[0], {"R6 we ", name}, int'(mem_we), ewe);
      if (ewe != 0) check(mem_wdata == 8'(ewd), {"R6 wdata ", name}, int'(mem_wdata), ewd);
      check(halted == eh[0], {"R9 halt ", name}, int'(halted), eh);
      if (!ok_cycle) $display("  cycle %0d phase %0d pc %0d", cyc, m_phase, m_pc);

      // advance the model to the next cycle
      case (m_phase)
        0: m_phase = 1;
        1: begin
          op = (m_rd >> 6) & 3; tgt = m_rd & 63;
          m_ir = tgt; m_op = op;
          if (op == NOR || op == ADD) m_phase = 2;
          else if (op == STA) begin m_pc = (m_pc + 1) & 63; m_phase = 0; end
          else if (m_c == 0) begin
            m_phase = (tgt == m_pc) ? 3 : 0;
            m_pc = tgt;
          end else begin
            m_c = 0; m_pc = (m_pc + 1) & 63; m_phase = 0;
          end
        end
        2: begin
          opd = m_rd;
          if (m_op == NOR) m_acc = (~(m_acc | opd)) & 255;
          else begin
            s = m_acc + opd; m_acc = s & 255; m_c = (s > 255) ? 1 : 0;
          end
          m_pc = (m_pc + 1) & 63; m_phase = 0;
        end
        default: ;
      endcase
      m_rd = int'(m_mem[ea]);
      if (ewe != 0) m_mem[ea] = 8'(ewd);
      if (m_phase == 3) begin post++; halt_pc = m_pc; end

      @(negedge clk);
      cyc++;
    end
    // watchdog: a program that never halts is a failure
    check(post >= 4, {"R9 watchdog ", name}, cyc, RUN_LIMIT);
    #1;
    check(halted == 1'b1, {"R9 halted at end ", name}, int'(halted), 1);
    if (halt_pc >= 0)
      check(mem_addr == 6'(halt_pc), {"R9 halt addr ", name}, int'(mem_addr), halt_pc);
  endtask

  int hpc;

  initial begin
    // R10: gcd(10,30) = 10 in word b
    load_gcd(10, 30);
    run_prog("gcd10_30", hpc);
    check(hpc == 13, "R10 halt pc", hpc, 13);
    check(mem[15] == 8'd10, "R10 b after gcd(10,30)", int'(mem[15]), 10);
    check(mem[14] == 8'd0, "R10 a after gcd(10,30)", int'(mem[14]), 0);

    // R10: second pair
    load_gcd(21, 14);
    run_prog("gcd21_14", hpc);
    check(mem[15] == 8'd7, "R10 b after gcd(21,14)", int'(mem[15]), 7);

    // R10: third pair
    load_gcd(9, 6);
    run_prog("gcd9_6", hpc);
    check(mem[15] == 8'd3, "R10 b after gcd(9,6)", int'(mem[15]), 3);

    // Flag rules
    load_flags();
    run_prog("flags", hpc);
    // R5: 0xFF + 0x01 wraps to zero (also R4: NOR with all-ones gave 0 first)
    check(mem[43] == 8'h00, "R5 wrap sum stored", int'(mem[43]), 0);
    // R4: NOR with zero of a zero accumulator gives all ones; R8 fall-through reached the store
    check(mem[44] == 8'hFF, "R4 nor result via R8 fall-through", int'(mem[44]), 255);
    // R7: both taken branches skip their stores, carry kept clear between them
    check(mem[45] == 8'h5A, "R7 skipped store untouched", int'(mem[45]), 90);
    // R5: carry-out sum after the taken branches
    check(mem[46] == 8'h00, "R5 second wrap sum", int'(mem[46]), 0);
    // R8: fall-through cleared carry, so the self-branch at 15 halted
    check(hpc == 15, "R8 halt after fall-through", hpc, 15);
    // R2: instruction words are never overwritten
    check(mem[15] == enc(JCC, 15), "R2 code intact", int'(mem[15]), int'(enc(JCC, 15)));

    // R1: reset again brings the core back to address 0, not halted
    rst_n = 1'b0;
    #1;
    check(halted == 1'b0, "R1 async reset clears halt", int'(halted), 0);
    check(mem_addr == 6'd0, "R1 async reset addr", int'(mem_addr), 0);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule